// File: doc/BRIEF.md
# Cascaded Dual-Divider Peripheral Clock Enable

The block turns one of four reference tick streams into a divided clock enable for a peripheral. Each reference arrives as a one-cycle strobe synchronous to the system clock, one strobe per reference period. A 2-bit field picks the stream. Two cascaded integer stages then divide it, and the product of the two stage factors is the total ratio. The block emits one single-cycle enable pulse for every N selected strobes. A disable bit suppresses the pulses without disturbing the count.

Software writes one configuration word holding the source, the two stage codes and the disable bit. The block reports the total ratio now in force, and 0 when either stage holds an illegal code. A new source or a new ratio is taken up only at the end of a divided period, so no output period is ever shortened. An illegal code stops the output at once. Parameters remove the source mux or change each stage into a 1-bit stage (factors 1/2 or 2/4) or a fixed factor of 1, for instances that need less.

Top module: `pcg_periph_clk`

## Requirements
- R1: After reset the ratio output reads 1, the disable bit is set, stage codes are 1 and the source is 0, so `clk_en_out` stays low.
- R2: A configuration write places the source in bits [1:0], stage A code in [4:2], stage B code in [7:5] and the disable bit in [8].
- R3: Stage codes 1 to 6 divide by that value, and the ratio output shows the product of both stages (1 to 36).
- R4: A code of 0 or 7 on either stage drives the ratio output to 0 in the cycle after the write and stops all pulses. A later legal write restarts the count from zero.
- R5: With total ratio N, `clk_en_out` is high for one cycle, in the cycle after every Nth strobe of the selected source.
- R6: Source code s (0 to 3) selects `ref_tick[s]`; strobes on the other inputs have no effect on the count or the output.
- R7: A source change written mid-period takes effect only after the old source completes the running period.
- R8: A ratio change written mid-period takes effect only after the running period completes at the old ratio.
- R9: With the disable bit at 1 no pulse is emitted while the count and ratio continue; clearing it lets pulses through again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 4 | One strobe per reference period, one bit per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word |
| clk_en_out | output | 1 | Divided clock enable pulse |
| ratio | output | 6 | Total divide ratio in force, 0 when stopped |

## Verification
The hardest cases are writes that arrive mid-period. A new source or ratio must wait for the old period to finish, which is visible only when strobes on the old and new sources are interleaved around the write. The stimulus first forces a known phase: an illegal code stops the counter, and a legal write restarts it from zero. It then feeds a counted number of strobes, writes the new setting, and feeds strobes on the new source that must produce nothing. Finishing the old period on the old source must produce exactly one pulse, in the position the old ratio predicts.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int FACT_W    = 3;
    localparam int RATIO_W   = 2 * FACT_W;
    localparam int FACT_MAX  = 6;
    localparam int RATIO_MAX = FACT_MAX * FACT_MAX;

    typedef enum logic [1:0] {
        STG_FULL    = 2'd0,  // 3-bit code, 1..6 legal
        STG_BIN_1_2 = 2'd1,  // 1-bit code, 0 -> /1, 1 -> /2
        STG_BIN_2_4 = 2'd2,  // 1-bit code, 0 -> /2, 1 -> /4
        STG_BYPASS  = 2'd3   // stage absent, factor 1
    } stage_mode_e;
endpackage

// File: rtl/pcg_stage_decode.sv
module pcg_stage_decode
    import pcg_pkg::*;
#(
    parameter stage_mode_e MODE = STG_FULL
) (
    input  logic [FACT_W-1:0] code,
    output logic [FACT_W-1:0] factor
);
    generate
        if (MODE == STG_FULL) begin : g_full
            assign factor = (code >= FACT_W'(1) && code <= FACT_W'(FACT_MAX)) ? code : '0;
        end else if (MODE == STG_BIN_1_2) begin : g_bin12
            assign factor = (code == FACT_W'(0)) ? FACT_W'(1) :
                            (code == FACT_W'(1)) ? FACT_W'(2) : '0;
        end else if (MODE == STG_BIN_2_4) begin : g_bin24
            assign factor = (code == FACT_W'(0)) ? FACT_W'(2) :
                            (code == FACT_W'(1)) ? FACT_W'(4) : '0;
        end else begin : g_bypass
            assign factor = FACT_W'(1);
        end
    endgenerate
endmodule

// File: rtl/pcg_src_pick.sv
module pcg_src_pick #(
    parameter int NUM_SRC = 4,
    parameter bit MUX_EN  = 1'b1,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    generate
        if (MUX_EN) begin : g_mux
            assign tick = ticks[sel];
        end else begin : g_fixed
            assign tick = ticks[0];
        end
    endgenerate
endmodule

// File: rtl/pcg_periph_clk.sv
module pcg_periph_clk
    import pcg_pkg::*;
#(
    parameter int          NUM_SRC      = 4,
    parameter bit          MUX_EN       = 1'b1,
    parameter stage_mode_e STAGE_A_MODE = STG_FULL,
    parameter stage_mode_e STAGE_B_MODE = STG_FULL,
    localparam int SEL_W = $clog2(NUM_SRC),
    localparam int CFG_W = SEL_W + 2 * FACT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ref_tick,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic               clk_en_out,
    output logic [RATIO_W-1:0] ratio
);
    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [FACT_W-1:0]  code_a;
        logic [FACT_W-1:0]  code_b;
        logic               dis;
        logic [SEL_W-1:0]   act_sel;
        logic [RATIO_W-1:0] act_n;
        logic [RATIO_W-1:0] cnt;
        logic               pulse;
    } state_t;

    localparam state_t RESET_ST = '{
        sel:     '0,
        code_a:  FACT_W'(1),
        code_b:  FACT_W'(1),
        dis:     1'b1,
        act_sel: '0,
        act_n:   RATIO_W'(1),
        cnt:     '0,
        pulse:   1'b0
    };

    state_t st_d, st_q;

    logic [FACT_W-1:0]  fact_a, fact_b;
    logic [RATIO_W-1:0] pend_n;
    logic               src_tick;

    pcg_stage_decode #(.MODE(STAGE_A_MODE)) u_dec_a (
        .code   (st_q.code_a),
        .factor (fact_a)
    );

    pcg_stage_decode #(.MODE(STAGE_B_MODE)) u_dec_b (
        .code   (st_q.code_b),
        .factor (fact_b)
    );

    assign pend_n = RATIO_W'(fact_a) * RATIO_W'(fact_b);

    pcg_src_pick #(.NUM_SRC(NUM_SRC), .MUX_EN(MUX_EN)) u_pick (
        .ticks (ref_tick),
        .sel   (st_q.act_sel),
        .tick  (src_tick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (cfg_we) begin
            st_d.sel    = cfg_wdata[SEL_W-1:0];
            st_d.code_a = cfg_wdata[SEL_W +: FACT_W];
            st_d.code_b = cfg_wdata[SEL_W + FACT_W +: FACT_W];
            st_d.dis    = cfg_wdata[CFG_W-1];
        end

        if (pend_n == '0) begin
            // illegal code: stop now
            st_d.act_n = '0;
            st_d.cnt   = '0;
        end else if (st_q.act_n == '0) begin
            // restart from a stopped state with a fresh count
            st_d.act_n   = pend_n;
            st_d.act_sel = st_q.sel;
            st_d.cnt     = '0;
        end else if (src_tick) begin
            if (st_q.cnt == st_q.act_n - RATIO_W'(1)) begin
                st_d.cnt     = '0;
                st_d.pulse   = ~st_q.dis;
                st_d.act_n   = pend_n;
                st_d.act_sel = st_q.sel;
            end else begin
                st_d.cnt = st_q.cnt + RATIO_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign clk_en_out = st_q.pulse;
    assign ratio      = st_q.act_n;

    logic               dis_q;
    logic [SEL_W-1:0]   act_sel_q;
    logic [RATIO_W-1:0] cnt_q;
    assign dis_q     = st_q.dis;
    assign act_sel_q = st_q.act_sel;
    assign cnt_q     = st_q.cnt;
endmodule

// File: rtl/pcg_periph_clk_chk.sv
module pcg_periph_clk_chk
    import pcg_pkg::*;
#(
    parameter int NUM_SRC = 4,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] ref_tick,
    input logic               clk_en_out,
    input logic [RATIO_W-1:0] ratio,
    input logic               dis_q,
    input logic [SEL_W-1:0]   act_sel_q,
    input logic [RATIO_W-1:0] cnt_q
);
    AST_RATIO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ratio <= RATIO_W'(RATIO_MAX)); // R3

    AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == '0) |-> !clk_en_out); // R4

    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> $past(|ref_tick)); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |=> !clk_en_out); // R5

    AST_SRC_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(act_sel_q)); // R7

    AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != '0) |-> (cnt_q < ratio)); // R8

    AST_GATED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |=> !clk_en_out); // R9
endmodule

bind pcg_periph_clk pcg_periph_clk_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .clk_en_out (clk_en_out),
    .ratio      (ratio),
    .dis_q      (dis_q),
    .act_sel_q  (act_sel_q),
    .cnt_q      (cnt_q)
);

// File: tb/pcg_periph_clk_bench.sv
module pcg_periph_clk_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ref_tick = '0;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       clk_en_out;
    logic [5:0] ratio;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pcg_periph_clk u_pcg_periph_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .clk_en_out (clk_en_out),
        .ratio      (ratio)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R2 layout: [1:0] source, [4:2] stage A, [7:5] stage B, [8] disable
    task automatic cfg_write(input int src, input int a, input int b, input bit dis);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {dis, 3'(b), 3'(a), 2'(src)};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // stop with an illegal code, then load the wanted setting from a zero count
    task automatic fresh(input int src, input int a, input int b, input bit dis);
        cfg_write(src, 0, 1, dis);
        cfg_write(src, a, b, dis);
        @(negedge clk);
    endtask

    task automatic run_ticks(input int src, input int n,
                             output int pulses, output int first, output int last);
        pulses = 0; first = 0; last = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            ref_tick = 4'(1 << src);
            @(negedge clk);
            ref_tick = '0;
            if (clk_en_out) begin
                pulses++;
                if (first == 0) first = i;
                last = i;
            end
        end
    endtask

    task automatic t_reset();
        int p, f, l;
        chk("R1", "ratio after reset", int'(ratio), 1);
        chk("R1", "enable after reset", int'(clk_en_out), 0);
        run_ticks(0, 4, p, f, l);
        chk("R1", "pulses while reset-disabled", p, 0);
    endtask

    task automatic t_product();
        int p, f, l;
        fresh(0, 2, 3, 1'b0);
        chk("R3", "ratio 2x3", int'(ratio), 6);
        run_ticks(0, 12, p, f, l);
        chk("R5", "pulses over 12 ticks /6", p, 2);
        chk("R5", "first pulse position /6", f, 6);
        fresh(0, 6, 6, 1'b0);
        chk("R3", "ratio 6x6", int'(ratio), 36);
        run_ticks(0, 72, p, f, l);
        chk("R5", "pulses over 72 ticks /36", p, 2);
        chk("R5", "first pulse position /36", f, 36);
        fresh(0, 1, 1, 1'b0);
        run_ticks(0, 5, p, f, l);
        chk("R5", "pulses at /1", p, 5);
        fresh(0, 5, 1, 1'b0);
        chk("R3", "ratio 5x1", int'(ratio), 5);
        run_ticks(0, 10, p, f, l);
        chk("R5", "first pulse position /5", f, 5);
    endtask

    task automatic t_illegal();
        int p, f, l;
        fresh(0, 2, 7, 1'b0);
        chk("R4", "ratio with code 7", int'(ratio), 0);
        run_ticks(0, 10, p, f, l);
        chk("R4", "pulses with code 7", p, 0);
        fresh(0, 0, 3, 1'b0);
        chk("R4", "ratio with code 0", int'(ratio), 0);
        run_ticks(0, 10, p, f, l);
        chk("R4", "pulses with code 0", p, 0);
    endtask

    task automatic t_select();
        int p, f, l;
        fresh(2, 2, 1, 1'b0);
        run_ticks(0, 4, p, f, l);
        chk("R6", "ticks on unselected source 0", p, 0);
        run_ticks(2, 4, p, f, l);
        chk("R6", "ticks on selected source 2", p, 2);
        fresh(3, 1, 2, 1'b0);
        run_ticks(1, 4, p, f, l);
        chk("R6", "ticks on unselected source 1", p, 0);
        run_ticks(3, 4, p, f, l);
        chk("R6", "ticks on selected source 3", p, 2);
    endtask

    task automatic t_src_switch();
        int p, f, l;
        fresh(0, 3, 1, 1'b0);
        run_ticks(0, 1, p, f, l);
        cfg_write(1, 3, 1, 1'b0);
        run_ticks(1, 3, p, f, l);
        chk("R7", "new source ignored mid-period", p, 0);
        run_ticks(0, 2, p, f, l);
        chk("R7", "old source completes period", p, 1);
        chk("R7", "old period end position", l, 2);
        run_ticks(1, 3, p, f, l);
        chk("R7", "new source after boundary", p, 1);
        run_ticks(0, 3, p, f, l);
        chk("R7", "old source ignored after switch", p, 0);
    endtask

    task automatic t_div_switch();
        int p, f, l;
        fresh(0, 4, 1, 1'b0);
        run_ticks(0, 1, p, f, l);
        cfg_write(0, 2, 1, 1'b0);
        chk("R8", "ratio held mid-period", int'(ratio), 4);
        run_ticks(0, 3, p, f, l);
        chk("R8", "old ratio completes", f, 3);
        chk("R8", "ratio after boundary", int'(ratio), 2);
        run_ticks(0, 4, p, f, l);
        chk("R8", "new ratio pulses", p, 2);
        chk("R8", "new ratio first position", f, 2);
    endtask

    task automatic t_gate();
        int p, f, l;
        fresh(0, 2, 1, 1'b0);
        cfg_write(0, 2, 1, 1'b1);
        run_ticks(0, 4, p, f, l);
        chk("R9", "pulses while disabled", p, 0);
        chk("R9", "ratio kept while disabled", int'(ratio), 2);
        cfg_write(0, 2, 1, 1'b0);
        run_ticks(0, 4, p, f, l);
        chk("R9", "pulses after re-enable", p, 2);
        chk("R9", "count phase kept", f, 2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_product();
        t_illegal();
        t_select();
        t_src_switch();
        t_div_switch();
        t_gate();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule